// File: doc/BRIEF.md
# Cascadable Serial DAC Word Receiver

This block is the digital front end of a 12-bit serial-input DAC. A host drives three wires into it: a serial clock, a serial data line and one strobe that acts as both chip select and load. While the strobe is low, each rising edge of the serial clock moves one data bit into a shift register, most significant bit first. When the strobe rises, the whole shift register is copied into a holding register. The holding register drives the parallel conversion code that goes to the analog ladder.

The bit that leaves the top of the shift register is driven on a serial output. Devices can therefore be chained: connect each serial output to the next device's data input and share the clock and strobe. One long frame then fills every device, and a single strobe edge updates all of them together. The block runs on a fast system clock. The three serial inputs are synchronised into that clock domain, and their edges are found by sampling. Nothing inside the block runs on the serial clock itself.

Top module: `sdac_word_rx`

## Requirements
- R1: After the synchronous active-low reset, the conversion code is 0 and the serial output is 0.
- R2: While the strobe is low, each rising edge of the serial clock shifts the data bit into bit 0 of the shift register and moves the other bits up by one. After a 12-bit frame and a strobe rise, the code equals the 12 bits sent, with the first bit sent at bit 11.
- R3: While the strobe is high, the serial clock has no effect. Toggling the clock and the data line changes neither the serial output nor the word that the next load presents.
- R4: The code changes only when the strobe rises, and it then takes the current shift register contents. While a frame is being shifted in, the code keeps its previous value.
- R5: The serial output always equals bit 11 of the shift register and updates after each accepted serial clock edge. During a new frame it first presents the previous word, starting with that word's bit 11.
- R6: If the serial clock is already high when the strobe falls, that fall counts as one rising clock edge and shifts in the current data bit.
- R7: A frame with more than 12 clock edges keeps shifting, so only the last 12 bits sent are loaded.
- R8: A frame with fewer than 12 edges loads the partly shifted register as it stands: the old bits moved up, with the new bits at the bottom.
- R9: With two devices chained through the serial output, a 24-bit frame loads the last 12 bits into the first device and the first 12 bits into the second device.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the host, asynchronous |
| ser_din | input | 1 | Serial data, sampled on the serial clock's rising edge |
| ser_csld | input | 1 | Strobe: low enables shifting, a rising edge loads the code |
| ser_dout | output | 1 | Bit 11 of the shift register, for chaining |
| dac_code | output | WORD_W | Holding register value, the conversion code |

## Verification
The bound checker tests the register-level rules on every cycle. After each accepted edge the register must shift by one with the synchronised data bit entering at the bottom, and the serial output must show the old next-to-top bit. While the strobe is high, the register and the serial output must not move. The code may change only on a load, and it must then equal the shift register as it was just before the load. The bench scenarios cover the behaviour seen across whole frames: the previous word coming out MSB first, frames longer and shorter than 12 bits, the extra edge when the clock is already high at the strobe fall, and the split of a 24-bit frame across two chained devices.

// File: rtl/sdac_pkg.sv
// Shared constants and types for the serial DAC word receiver.
package sdac_pkg;
    localparam int unsigned SDAC_WORD_W      = 12;
    localparam int unsigned SDAC_SYNC_STAGES = 2;

    // The three serial lines, bundled so that one synchroniser carries all of them.
    typedef struct packed {
        logic sclk;
        logic din;
        logic csld;
    } sdac_lines_t;

    localparam int unsigned SDAC_LINES_W = $bits(sdac_lines_t);
endpackage

// File: rtl/sdac_sync.sv
// Multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes each bit is a slow level that is sampled on its own. All bits go
// through the same number of stages, so their relative timing is kept.
module sdac_sync #(
    parameter int unsigned STAGES = 2,
    parameter int unsigned WIDTH  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First stage: capture the raw asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // Later stages: re-register to let metastability settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_strobe_edge.sv
// Turns the synchronised serial clock and strobe into single-cycle events.
// The serial clock is gated by a low strobe before its edge is detected. As a
// result, a strobe fall while the clock is high shows up as a clock edge,
// which is the documented extra-edge behaviour. A strobe rise gives a load.
module sdac_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic csld_s,
    output logic shift_en,
    output logic load_stb
);
    logic gate_now;
    logic gate_q;
    logic csld_q;

    assign gate_now = sclk_s & ~csld_s;

    // Keep last cycle's gated clock and strobe for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            csld_q <= 1'b0;
        end else begin
            gate_q <= gate_now;
            csld_q <= csld_s;
        end
    end

    assign shift_en = gate_now & ~gate_q;
    assign load_stb = csld_s & ~csld_q;
endmodule

// File: rtl/sdac_shift.sv
// Serial-in shift register. On each enable the word moves up by one bit and
// the new data bit enters at bit 0, so a frame sent MSB first lands in order.
module sdac_shift #(
    parameter int unsigned WORD_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [WORD_W-1:0] word
);
    // Shift one bit in on each accepted serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WORD_W-2:0], din};
    end
endmodule

// File: rtl/sdac_word_rx.sv
// Device-side front end of a cascadable serial DAC.
// Assumes the serial clock stays low and high for at least SYNC_STAGES+1
// system clocks, and that data is stable around its rising edge.
// The holding register drives the conversion code. Bit WORD_W-1 of the shift
// register drives the chain output.
module sdac_word_rx #(
    parameter int unsigned WORD_W      = sdac_pkg::SDAC_WORD_W,
    parameter int unsigned SYNC_STAGES = sdac_pkg::SDAC_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_din,
    input  logic              ser_csld,
    output logic              ser_dout,
    output logic [WORD_W-1:0] dac_code
);
    localparam int unsigned LW = sdac_pkg::SDAC_LINES_W;

    sdac_pkg::sdac_lines_t lines_raw;
    sdac_pkg::sdac_lines_t lines_s;
    logic [LW-1:0]         lines_s_vec;
    logic                  shift_en;
    logic                  load_stb;
    logic                  din_s;
    logic                  csld_s;
    logic [WORD_W-1:0]     shift_word;
    logic [WORD_W-1:0]     hold_q;

    assign lines_raw = '{sclk: ser_clk, din: ser_din, csld: ser_csld};

    sdac_sync #(.STAGES(SYNC_STAGES), .WIDTH(LW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (lines_raw),
        .q     (lines_s_vec)
    );

    assign lines_s = lines_s_vec;
    assign din_s   = lines_s.din;
    assign csld_s  = lines_s.csld;

    sdac_strobe_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (lines_s.sclk),
        .csld_s   (csld_s),
        .shift_en (shift_en),
        .load_stb (load_stb)
    );

    sdac_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .din      (din_s),
        .word     (shift_word)
    );

    // Copy the shifted word into the holding register on each strobe rise.
    always_ff @(posedge clk) begin
        if (!rst_n)        hold_q <= '0;
        else if (load_stb) hold_q <= shift_word;
    end

    assign dac_code = hold_q;
    assign ser_dout = shift_word[WORD_W-1];
endmodule

// File: rtl/sdac_word_rx_chk.sv
// Checker for sdac_word_rx. It watches the events between the edge detector,
// the shift register and the holding register, and is bound into the top.
module sdac_word_rx_chk #(
    parameter int unsigned WORD_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              shift_en,
    input logic              load_stb,
    input logic              din_s,
    input logic              csld_s,
    input logic [WORD_W-1:0] shift_word,
    input logic              ser_dout,
    input logic [WORD_W-1:0] dac_code
);
    // R1: both registers are clear on the first cycle after reset.
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dac_code == '0 && ser_dout == 1'b0));

    // R2: an accepted edge moves the word up and takes in the synced data bit.
    a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> shift_word == {$past(shift_word[WORD_W-2:0]), $past(din_s)});

    // R3: a high strobe freezes the shift register.
    a_r3_hold_high: assert property (@(posedge clk) disable iff (!rst_n)
        csld_s |=> $stable(shift_word));

    // R3: a high strobe freezes the chain output.
    a_r3_dout_still: assert property (@(posedge clk) disable iff (!rst_n)
        csld_s |=> $stable(ser_dout));

    // R4: without a load the code does not move.
    a_r4_code_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> $stable(dac_code));

    // R4: a load copies the shift register.
    a_r4_load_copy: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> dac_code == $past(shift_word));

    // R5: after a shift the chain output shows the old next-to-top bit.
    a_r5_dout_next: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> ser_dout == $past(shift_word[WORD_W-2]));

    // R4: shift and load never coincide, since a high strobe gates the clock.
    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(shift_en && load_stb));
endmodule

bind sdac_word_rx sdac_word_rx_chk #(.WORD_W(WORD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_en   (shift_en),
    .load_stb   (load_stb),
    .din_s      (din_s),
    .csld_s     (csld_s),
    .shift_word (shift_word),
    .ser_dout   (ser_dout),
    .dac_code   (dac_code)
);

// File: tb/sdac_word_rx_tb.sv
// Scoreboard bench. Two devices are chained. The driver tasks keep a bit-level
// model of both shift registers and queue the expected codes on each load.
// The monitor pops each entry and compares it with both code ports.
module sdac_word_rx_tb;
    localparam int W    = 12;
    localparam int HALF = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic din = 1'b0;
    logic csld = 1'b1;
    logic dout1, dout2;
    logic [W-1:0] code1, code2;

    int vectors = 0;
    int errors  = 0;

    logic [W-1:0] m1 = '0;
    logic [W-1:0] m2 = '0;
    logic [W-1:0] q_c1 [$];
    logic [W-1:0] q_c2 [$];
    string        q_tag [$];

    always #10 clk = ~clk;

    sdac_word_rx u_dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_din(din),
        .ser_csld(csld), .ser_dout(dout1), .dac_code(code1)
    );

    sdac_word_rx u_dut_nx (
        .clk(clk), .rst_n(rst_n), .ser_clk(sclk), .ser_din(dout1),
        .ser_csld(csld), .ser_dout(dout2), .dac_code(code2)
    );

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One accepted edge in the model: device 2 takes device 1's old top bit.
    task automatic model_edge(input logic b);
        m2 = {m2[W-2:0], m1[W-1]};
        m1 = {m1[W-2:0], b};
    endtask

    task automatic check_dout(input string tag);
        check(dout1 == m1[W-1], tag, "dout dev1", {11'b0, dout1}, {11'b0, m1[W-1]});
        check(dout2 == m2[W-1], tag, "dout dev2", {11'b0, dout2}, {11'b0, m2[W-1]});
    endtask

    // One serial clock pulse carrying bit b.
    task automatic pulse(input logic b, input string tag);
        din = b;
        wait_n(HALF);
        sclk = 1'b1;
        if (!csld) model_edge(b);
        wait_n(HALF);
        check_dout(tag);
        sclk = 1'b0;
        wait_n(HALF);
    endtask

    // Raise the strobe and queue the expected codes.
    task automatic load(input string tag);
        check(code1 == q_last1(), tag, "code before load", code1, q_last1());
        csld = 1'b1;
        q_c1.push_back(m1);
        q_c2.push_back(m2);
        q_tag.push_back(tag);
        wait_n(12);
    endtask

    logic [W-1:0] last1 = '0;
    function automatic logic [W-1:0] q_last1();
        return last1;
    endfunction

    // Send the low n bits of v, MSB first, and then load.
    task automatic frame(input logic [31:0] v, input int n, input string tag);
        csld = 1'b0;
        wait_n(HALF);
        for (int i = n - 1; i >= 0; i--) pulse(v[i], tag);
        load(tag);
    endtask

    // Monitor: compare each queued expectation once the load has settled.
    initial begin
        forever begin
            wait (q_c1.size() != 0);
            wait_n(6);
            begin
                logic [W-1:0] e1, e2;
                string t;
                e1 = q_c1.pop_front();
                e2 = q_c2.pop_front();
                t  = q_tag.pop_front();
                check(code1 == e1, t, "code dev1", code1, e1);
                check(code2 == e2, t, "code dev2", code2, e2);
                last1 = e1;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(2);
        // R1: reset state
        check(code1 == '0, "R1", "code after reset", code1, '0);
        check(dout1 == 1'b0, "R1", "dout after reset", {11'b0, dout1}, '0);
        check(code2 == '0, "R1", "code dev2 after reset", code2, '0);

        // R2 / R5: plain 12-bit frames; the second shows the first coming out.
        frame(32'hA5C, 12, "R2");
        frame(32'h3F1, 12, "R5");

        // R3: clock and data toggles with the strobe high have no effect.
        for (int i = 0; i < 6; i++) pulse(i[0], "R3");
        check(code1 == last1, "R3", "code with strobe high", code1, last1);
        frame(32'h0, 0, "R3");

        // R7: 16 edges, the last 12 are kept.
        frame(32'hBEEF, 16, "R7");

        // R8: a 5-edge frame loads a partly shifted word.
        frame(32'h16, 5, "R8");

        // R6: clock already high when the strobe falls gives one extra edge.
        din = 1'b1;
        wait_n(HALF);
        sclk = 1'b1;
        wait_n(HALF);
        csld = 1'b0;
        model_edge(1'b1);
        wait_n(HALF);
        check_dout("R6");
        sclk = 1'b0;
        wait_n(HALF);
        for (int i = 10; i >= 0; i--) pulse(i[1], "R6");
        load("R6");

        // R9: a 24-bit frame fills both chained devices.
        frame(32'h123ABC, 24, "R9");
        wait_n(10);
        check(code1 == 12'hABC, "R9", "dev1 chain word", code1, 12'hABC);
        check(code2 == 12'h123, "R9", "dev2 chain word", code2, 12'h123);

        // R4: a fresh word of all ones, code held until the strobe rises.
        frame(32'hFFF, 12, "R4");
        wait_n(10);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule